// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block keeps a 63-bit cycle counter that advances once per clock and compares it with a software-loaded limit. When the two agree, or when a newly written limit already lies at or behind the running count, the block emits a single-cycle match pulse. The same pulse sets one bit of a software-interrupt set vector. Bit 63 of each 64-bit register word is a control flag. In the count word it is a trap flag for non-privileged reads. In the limit word it is a flag that suppresses the match interrupt.

Several copies are meant to sit side by side: a per-core tick, a system tick and a hypervisor system tick. A parameter of enumerated type selects the copy, and that choice decides which interrupt bit the copy drives. Privilege checks on reads belong to the surrounding logic.

Top module: `tick_timer`

## Requirements
- R1: While `por` is high, the count read word is 0x8000_0000_0000_0000 (counter zero, trap flag set), limit read bit 63 is 1, and `match_pulse` and `softint_set` are 0.
- R2: A cycle with `rst` high and `por` low clears the counter to zero and sets the interrupt-disable flag. It leaves the trap flag at its previous value.
- R3: A count write loads bits [62:0] into the counter and bit 63 into the trap flag. The count read word is {trap flag, counter}, so it reads back as the written word in the following cycle.
- R4: A limit write stores bits [62:0] as the compare value and bit 63 as the disable flag. The limit read word is {disable flag, compare value}.
- R5: With the flag clear and a nonzero compare value, `match_pulse` is high in the cycle after the one in which the counter equals the compare value.
- R6: A match sets bit 0 of `softint_set` in the tick kind, and bit 16 in both system-tick kinds. No other bit is set, and `softint_set` is zero when there is no pulse.
- R7: A compare value of zero, or a set disable flag, produces no pulse. A match that occurs while disabled is discarded.
- R8: A limit written with a value at or below the count of the write cycle produces one pulse two cycles after the write edge, that is, on the next tick.
- R9: The counter rises by one each clock without a write and wraps from 2^63-1 to zero silently.
- R10: Each match produces a pulse exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock (nominal 100 MHz) |
| por | input | 1 | Power-on reset, synchronous, active high |
| rst | input | 1 | Warm reset, synchronous, active high |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | 64 | Count write word: [63] trap flag, [62:0] count |
| cmp_wr | input | 1 | Limit register write strobe |
| cmp_wdata | input | 64 | Limit write word: [63] disable flag, [62:0] compare value |
| cnt_rdata | output | 64 | Count read word {trap flag, counter} |
| cmp_rdata | output | 64 | Limit read word {disable flag, compare value} |
| match_pulse | output | 1 | One-cycle match indication |
| softint_set | output | 17 | Software-interrupt bits to set on a match |

## Verification
A table of count/limit pairs exercises matching in several regimes. Some limits lie a few ticks ahead, which times the equality path. One limit is exactly one ahead, one equals the current count and one lies far behind, which together separate the equality path from the late-limit path. One pair sits at the top of the 63-bit range. Zero limits and disabled limits show that suppression works for both causes. Each window also checks that the pulse stays low before and after its single cycle, and it checks the interrupt bit chosen by the tick kind and by the hypervisor kind. Directed sequences cover power-on state, warm reset with both trap-flag values (to tell it apart from power-on), plain counting, and the silent wrap.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic [1:0] {TK_TICK, TK_SYS, TK_HYP} tick_kind_e;

  localparam int SI_W       = 17;
  localparam int SI_TM_BIT  = 0;
  localparam int SI_SM_BIT  = 16;

  function automatic int si_bit(tick_kind_e k);
    return (k == TK_TICK) ? SI_TM_BIT : SI_SM_BIT;
  endfunction
endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 63
) (
  input  logic             clk,
  input  logic             por,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W:0]   wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic             trap_q
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (por) begin
      cnt_q  <= '0;
      trap_q <= 1'b1;
    end else if (rst) begin
      cnt_q  <= '0;
    end else if (wr_en) begin
      cnt_q  <= wr_data[CNT_W-1:0];
      trap_q <= wr_data[CNT_W];
    end else begin
      cnt_q  <= cnt_q + STEP;
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (por || rst)
    !wr_en |=> cnt_q == $past(cnt_q) + STEP); // R9
  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (por || rst)
    wr_en |=> cnt_q == $past(wr_data[CNT_W-1:0]) && trap_q == $past(wr_data[CNT_W])); // R3
endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
  parameter int CNT_W = 63
) (
  input  logic             clk,
  input  logic             por,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W:0]   wr_data,
  input  logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             dis_q,
  output logic             fire_q
);
  logic late_q;
  logic hit;
  logic live;

  assign hit  = (cnt_q == cmp_q) || late_q;
  assign live = !dis_q && (cmp_q != '0);

  always_ff @(posedge clk) begin
    if (por) begin
      cmp_q  <= '0;
      dis_q  <= 1'b1;
      late_q <= 1'b0;
      fire_q <= 1'b0;
    end else if (rst) begin
      dis_q  <= 1'b1;
      late_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= hit && live;
      if (wr_en) begin
        cmp_q  <= wr_data[CNT_W-1:0];
        dis_q  <= wr_data[CNT_W];
        late_q <= (wr_data[CNT_W-1:0] <= cnt_q);
      end else if (hit) begin
        late_q <= 1'b0;
      end
    end
  end

  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (por || rst)
    dis_q |=> !fire_q); // R7
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (por || rst)
    (cmp_q == '0) |=> !fire_q); // R7
  AST_LATE_FIRE: assert property (@(posedge clk) disable iff (por || rst)
    (late_q && !dis_q && cmp_q != '0) |=> fire_q); // R8
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter tick_pkg::tick_kind_e KIND = tick_pkg::TK_TICK,
  parameter int CNT_W = 63,
  parameter int SI_W  = tick_pkg::SI_W
) (
  input  logic            clk,
  input  logic            por,
  input  logic            rst,
  input  logic            cnt_wr,
  input  logic [CNT_W:0]  cnt_wdata,
  input  logic            cmp_wr,
  input  logic [CNT_W:0]  cmp_wdata,
  output logic [CNT_W:0]  cnt_rdata,
  output logic [CNT_W:0]  cmp_rdata,
  output logic            match_pulse,
  output logic [SI_W-1:0] softint_set
);
  localparam int SI_BIT = tick_pkg::si_bit(KIND);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_q;
  logic             trap_q;
  logic             dis_q;
  logic             fire_q;

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .por(por), .rst(rst),
    .wr_en(cnt_wr), .wr_data(cnt_wdata),
    .cnt_q(cnt_q), .trap_q(trap_q)
  );

  tick_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .por(por), .rst(rst),
    .wr_en(cmp_wr), .wr_data(cmp_wdata),
    .cnt_q(cnt_q),
    .cmp_q(cmp_q), .dis_q(dis_q), .fire_q(fire_q)
  );

  assign cnt_rdata   = {trap_q, cnt_q};
  assign cmp_rdata   = {dis_q, cmp_q};
  assign match_pulse = fire_q;

  for (genvar i = 0; i < SI_W; i++) begin : g_si
    if (i == SI_BIT) begin : g_hit
      assign softint_set[i] = fire_q;
    end else begin : g_zero
      assign softint_set[i] = 1'b0;
    end
  end

  AST_SI_ONEHOT: assert property (@(posedge clk) disable iff (por)
    $onehot0(softint_set)); // R6
  AST_SI_FOLLOWS: assert property (@(posedge clk) disable iff (por)
    (softint_set != '0) == match_pulse); // R6
  AST_POR_QUIET: assert property (@(posedge clk)
    $past(por) |-> !match_pulse); // R1
endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  localparam int NV = 8;
  localparam int WIN = 12;
  localparam logic [63:0] TOP = 64'h8000_0000_0000_0000;

  localparam logic [63:0] VC [0:NV-1] = '{
    64'd100, TOP | 64'd100, 64'd100, 64'd200,
    64'd5, 64'd5, TOP, 64'h7FFF_FFFF_FFFF_FFFD};
  localparam logic [63:0] VL [0:NV-1] = '{
    64'd105, 64'd101, 64'd100, 64'd50,
    64'd0, TOP | 64'd8, 64'd3, 64'h7FFF_FFFF_FFFF_FFFF};

  logic clk = 1'b0;
  logic por, rst, cnt_wr, cmp_wr;
  logic [63:0] cnt_wdata, cmp_wdata;
  logic [63:0] cnt_rdata, cmp_rdata, cnt_rdata_s, cmp_rdata_s;
  logic match_pulse, match_pulse_s;
  logic [16:0] softint_set, softint_set_s;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  tick_timer #(.KIND(tick_pkg::TK_TICK)) dut (
    .clk(clk), .por(por), .rst(rst), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .cnt_rdata(cnt_rdata),
    .cmp_rdata(cmp_rdata), .match_pulse(match_pulse), .softint_set(softint_set));

  tick_timer #(.KIND(tick_pkg::TK_HYP)) dut_sys (
    .clk(clk), .por(por), .rst(rst), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .cnt_rdata(cnt_rdata_s),
    .cmp_rdata(cmp_rdata_s), .match_pulse(match_pulse_s), .softint_set(softint_set_s));

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] prev;
    por = 1'b1; rst = 1'b0; cnt_wr = 1'b0; cmp_wr = 1'b0;
    cnt_wdata = '0; cmp_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cnt_rdata == TOP, "R1 count", cnt_rdata, TOP);
    chk(cmp_rdata[63] == 1'b1, "R1 disable", {63'd0, cmp_rdata[63]}, 64'd1);
    chk(!match_pulse && softint_set == '0, "R1 pulse", {46'd0, softint_set, match_pulse}, 64'd0);
    por = 1'b0;

    // R9 plain counting
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      prev = cnt_rdata;
      @(negedge clk);
      chk(cnt_rdata == prev + 64'd1, "R9 step", cnt_rdata, prev + 64'd1);
    end

    // table of count/limit vectors
    for (int v = 0; v < NV; v++) begin
      logic en;
      int   exp_n;
      en = !VL[v][63] && (VL[v][62:0] != 63'd0);
      exp_n = (VL[v][62:0] > VC[v][62:0]) ? int'(VL[v][62:0] - VC[v][62:0]) : 1;
      cmp_wr = 1'b1; cmp_wdata = TOP;
      @(negedge clk);
      cmp_wr = 1'b0; cnt_wr = 1'b1; cnt_wdata = VC[v];
      @(negedge clk);
      cnt_wr = 1'b0;
      chk(cnt_rdata == VC[v], "R3 readback", cnt_rdata, VC[v]);
      cmp_wr = 1'b1; cmp_wdata = VL[v];
      @(negedge clk);
      cmp_wr = 1'b0;
      chk(!match_pulse, "R10 quiet before", {63'd0, match_pulse}, 64'd0);
      for (int n = 1; n <= WIN; n++) begin
        logic want;
        @(negedge clk);
        want = en && (n == exp_n);
        if (n == 1)
          chk(cmp_rdata == VL[v], "R4 readback", cmp_rdata, VL[v]);
        if (!en)
          chk(match_pulse == 1'b0, "R7 suppressed", {63'd0, match_pulse}, 64'd0);
        else if (VL[v][62:0] <= VC[v][62:0])
          chk(match_pulse == want, "R8 late limit", {63'd0, match_pulse}, {63'd0, want});
        else if (n == exp_n)
          chk(match_pulse == want, "R5 equality", {63'd0, match_pulse}, {63'd0, want});
        else
          chk(match_pulse == want, "R10 single cycle", {63'd0, match_pulse}, {63'd0, want});
        chk(softint_set == (want ? 17'h00001 : 17'h0), "R6 tick bit",
            {47'd0, softint_set}, want ? 64'h1 : 64'h0);
        chk(softint_set_s == (want ? 17'h10000 : 17'h0), "R6 system bit",
            {47'd0, softint_set_s}, want ? 64'h10000 : 64'h0);
      end
    end

    // R2 warm reset keeps trap flag
    for (int t = 0; t < 2; t++) begin
      logic [63:0] w;
      w = (t == 0) ? 64'h123 : (TOP | 64'h456);
      cnt_wr = 1'b1; cnt_wdata = w;
      @(negedge clk);
      cnt_wr = 1'b0; rst = 1'b1;
      @(negedge clk);
      chk(cnt_rdata == (w & TOP), "R2 count", cnt_rdata, w & TOP);
      chk(cmp_rdata[63] == 1'b1, "R2 disable", {63'd0, cmp_rdata[63]}, 64'd1);
      rst = 1'b0;
    end

    // R9 wrap with no pulse
    cnt_wr = 1'b1; cnt_wdata = 64'h7FFF_FFFF_FFFF_FFFE;
    @(negedge clk);
    cnt_wr = 1'b0;
    chk(cnt_rdata == 64'h7FFF_FFFF_FFFF_FFFE, "R9 pre-wrap", cnt_rdata, 64'h7FFF_FFFF_FFFF_FFFE);
    @(negedge clk);
    chk(cnt_rdata == 64'h7FFF_FFFF_FFFF_FFFF, "R9 top", cnt_rdata, 64'h7FFF_FFFF_FFFF_FFFF);
    @(negedge clk);
    chk(cnt_rdata == 64'd0, "R9 wrap", cnt_rdata, 64'd0);
    chk(!match_pulse, "R9 no pulse", {63'd0, match_pulse}, 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule